// File: doc/BRIEF.md
# Host Access Port for Video Memory

This block sits between a host processor and the 64K-word video memory of a tile-based display controller. The host sees three byte-wide locations. One location selects an internal register by number. The other two are the low and high halves of a 16-bit data window onto the selected register. The block keeps a write pointer and a read pointer into video memory, a holding latch for the low half of a word being written, and a one-word prefetch buffer that serves host reads.

Only a high-half access ever reaches memory. A low-half write to the data register is held in the latch. The following high-half write sends the assembled word out as a single-word write request. On the read side, loading the upper half of the read pointer fetches a word into the buffer. Each high-half read of the data register then hands the host the buffered word and starts the next fetch. After each memory access, the pointer it used moves forward by a stride. That stride comes from a two-bit field in the control register.

Requests go out through a request/grant handshake to an external memory arbiter. While a request is outstanding the block reports itself busy. Any host access that arrives during that time is held off with a wait signal and is completed later, never lost.

Top module: `vramHostPort`

## Requirements
- R1: A write to host location 0 loads the register number from bits 4..0 of the written byte. Bits 7..5 are ignored. Register numbers are 0 = write pointer, 1 = read pointer, 2 = memory data, 5 = control.
- R2: With register 2 selected, a write to host location 2 (low half) only updates the holding latch and raises no memory request. Repeated low writes keep only the last value.
- R3: With register 2 selected, a write to host location 3 (high half) issues one memory write of {written byte, latch} at the write pointer. After the grant, the write pointer advances by the stride.
- R4: Either byte of the write pointer or the read pointer (registers 0 and 1, locations 2 and 3) can be written alone. The write takes effect at once and leaves the other byte unchanged.
- R5: A high-half write of the read pointer issues a memory read at the new pointer value, loads the buffer with the returned word and then advances the read pointer by the stride. A low-half write of the read pointer issues no request.
- R6: With register 2 selected, a read of location 2 returns buffer bits 7..0. A read of location 3 returns buffer bits 15..8 and then reloads the buffer from the read pointer and advances the pointer.
- R7: With any register other than 2 selected, reads of locations 2 and 3 return the buffer's low and high halves and cause no request and no pointer change.
- R8: Both pointers are 16-bit word addresses and wrap from 0xFFFF to 0x0000.
- R9: The stride comes from bits 12..11 of the control register, which are bits 4..3 of a high-half write to register 5. The encoding is 00 = 1, 01 = 32, 10 = 64 and 11 = 128 words.
- R10: A request holds its address and data steady until it is granted, and busy is high during that time. A host access presented while busy sees wait high and is carried out after the grant, not dropped.
- R11: After reset both pointers, the latch, the buffer and the register number are zero, the stride is 1, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | Host access strobe, held until wait is low |
| cpuWr | input | 1 | 1 = host write, 0 = host read |
| cpuAddr | input | 2 | Host location: 0 register number, 2 data low, 3 data high |
| cpuWdata | input | 8 | Host write byte |
| cpuRdata | output | 8 | Host read byte |
| cpuWait | output | 1 | Host access held off this cycle |
| busy | output | 1 | A memory request is outstanding |
| vramReq | output | 1 | Memory request |
| vramWe | output | 1 | 1 = write request, 0 = read request |
| vramAddr | output | 16 | Memory word address |
| vramWdata | output | 16 | Memory write word |
| vramGnt | input | 1 | Grant, completes the request in this cycle |
| vramRdata | input | 16 | Read word, valid with the grant |

## Verification
The assertions assume that the arbiter gives a grant only while a request is present and that read data is valid in the grant cycle. They also assume the host holds its strobe and operands steady until wait drops. The bench's memory model raises a grant only in response to a request, after a delay that changes between phases and reaches several cycles. Its host tasks drive each access at the falling edge and keep it in place until a rising edge has passed with wait low.

// File: rtl/hostPortPkg.sv
package hostPortPkg;
  localparam int ADDR_W = 16;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 5;
  localparam int PORT_W = 2;
  localparam int STEP_W = 2;
  // bit position of the stride field inside the high control byte (word bits 12..11)
  localparam int STEP_LSB = 11 - BYTE_W;

  localparam logic [IDX_W-1:0] IDX_WRPTR = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_RDPTR = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_CTRL  = IDX_W'(5);

  localparam logic [PORT_W-1:0] PORT_INDEX = PORT_W'(0);
  localparam logic [PORT_W-1:0] PORT_LO    = PORT_W'(2);
  localparam logic [PORT_W-1:0] PORT_HI    = PORT_W'(3);

  typedef struct packed {
    logic idxLoad;
    logic loLoad;
    logic hiLoad;
    logic issueWrite;
    logic issueRead;
    logic readFromPtr;
    logic doneWrite;
    logic doneRead;
  } strobeT;

  function automatic logic [ADDR_W-1:0] strideOf(input logic [STEP_W-1:0] sel);
    logic [ADDR_W-1:0] one;
    one = ADDR_W'(1);
    case (sel)
      2'b00:   strideOf = one;
      2'b01:   strideOf = one << 5;
      2'b10:   strideOf = one << 6;
      default: strideOf = one << 7;
    endcase
  endfunction
endpackage

// File: rtl/hostPortCtrl.sv
module hostPortCtrl
  import hostPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [PORT_W-1:0] cpuAddr,
  input  logic [IDX_W-1:0]  regIndex,
  input  logic              vramGnt,
  output strobeT            strb,
  output logic              cpuWait,
  output logic              busy,
  output logic              vramReq,
  output logic              vramWe
);
  logic pending;
  logic pendWe;
  logic accept;
  logic isIdx, isLo, isHi;

  assign accept = cpuSel & ~pending;
  assign isIdx  = (cpuAddr == PORT_INDEX);
  assign isLo   = (cpuAddr == PORT_LO);
  assign isHi   = (cpuAddr == PORT_HI);

  always_comb begin
    strb             = '0;
    strb.idxLoad     = accept & cpuWr & isIdx;
    strb.loLoad      = accept & cpuWr & isLo;
    strb.hiLoad      = accept & cpuWr & isHi;
    strb.issueWrite  = accept & cpuWr & isHi & (regIndex == IDX_DATA);
    strb.readFromPtr = accept & cpuWr & isHi & (regIndex == IDX_RDPTR);
    strb.issueRead   = strb.readFromPtr
                     | (accept & ~cpuWr & isHi & (regIndex == IDX_DATA));
    strb.doneWrite   = pending & vramGnt & pendWe;
    strb.doneRead    = pending & vramGnt & ~pendWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      pendWe  <= 1'b0;
    end else if (strb.issueWrite || strb.issueRead) begin
      pending <= 1'b1;
      pendWe  <= strb.issueWrite;
    end else if (pending && vramGnt) begin
      pending <= 1'b0;
    end
  end

  assign vramReq = pending;
  assign vramWe  = pendWe;
  assign busy    = pending;
  assign cpuWait = cpuSel & pending;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    vramReq && !vramGnt |=> vramReq && busy); // R10
  AST_LO_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cpuSel && cpuWr && cpuAddr == PORT_LO |=> !vramReq); // R2
  AST_HI_WR_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cpuSel && cpuWr && cpuAddr == PORT_HI && regIndex == IDX_DATA
    |=> vramReq && vramWe); // R3
  AST_IDLE_RD_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy && cpuSel && !cpuWr && cpuAddr == PORT_HI && regIndex != IDX_DATA
    |=> !vramReq); // R7
endmodule

// File: rtl/hostPortData.sv
module hostPortData
  import hostPortPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [PORT_W-1:0] cpuAddr,
  input  logic [BYTE_W-1:0] cpuWdata,
  input  logic [WORD_W-1:0] vramRdata,
  output logic [IDX_W-1:0]  regIndex,
  output logic [BYTE_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] vramAddr,
  output logic [WORD_W-1:0] vramWdata
);
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic [BYTE_W-1:0] loLatch;
  logic [WORD_W-1:0] rdBuf;
  logic [STEP_W-1:0] strideSel;
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] reqAddr;
  logic [WORD_W-1:0] reqData;

  assign stride = strideOf(strideSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regIndex <= '0;
    end else if (strb.idxLoad) begin
      regIndex <= cpuWdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      loLatch   <= '0;
      strideSel <= '0;
    end else begin
      if (strb.loLoad) begin
        case (regIndex)
          IDX_WRPTR: wrPtr[BYTE_W-1:0] <= cpuWdata;
          IDX_RDPTR: rdPtr[BYTE_W-1:0] <= cpuWdata;
          IDX_DATA:  loLatch           <= cpuWdata;
          default:   ;
        endcase
      end
      if (strb.hiLoad) begin
        case (regIndex)
          IDX_WRPTR: wrPtr[ADDR_W-1:BYTE_W] <= cpuWdata;
          IDX_RDPTR: rdPtr[ADDR_W-1:BYTE_W] <= cpuWdata;
          IDX_CTRL:  strideSel <= cpuWdata[STEP_LSB +: STEP_W];
          default:   ;
        endcase
      end
      if (strb.doneWrite) wrPtr <= wrPtr + stride;
      if (strb.doneRead)  rdPtr <= rdPtr + stride;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBuf <= '0;
    end else if (strb.doneRead) begin
      rdBuf <= vramRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr <= '0;
      reqData <= '0;
    end else if (strb.issueWrite) begin
      reqAddr <= wrPtr;
      reqData <= {cpuWdata, loLatch};
    end else if (strb.issueRead) begin
      reqAddr <= strb.readFromPtr ? {cpuWdata, rdPtr[BYTE_W-1:0]} : rdPtr;
    end
  end

  always_comb begin
    case (cpuAddr)
      PORT_LO: cpuRdata = rdBuf[BYTE_W-1:0];
      PORT_HI: cpuRdata = rdBuf[WORD_W-1:BYTE_W];
      default: cpuRdata = '0;
    endcase
  end

  assign vramAddr  = reqAddr;
  assign vramWdata = reqData;

  AST_BUF_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doneRead |=> $stable(rdBuf)); // R7
endmodule

// File: rtl/vramHostPort.sv
module vramHostPort
  import hostPortPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuSel,
  input  logic        cpuWr,
  input  logic [1:0]  cpuAddr,
  input  logic [7:0]  cpuWdata,
  output logic [7:0]  cpuRdata,
  output logic        cpuWait,
  output logic        busy,
  output logic        vramReq,
  output logic        vramWe,
  output logic [15:0] vramAddr,
  output logic [15:0] vramWdata,
  input  logic        vramGnt,
  input  logic [15:0] vramRdata
);
  strobeT           strb;
  logic [IDX_W-1:0] regIndex;

  hostPortCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuSel   (cpuSel),
    .cpuWr    (cpuWr),
    .cpuAddr  (cpuAddr),
    .regIndex (regIndex),
    .vramGnt  (vramGnt),
    .strb     (strb),
    .cpuWait  (cpuWait),
    .busy     (busy),
    .vramReq  (vramReq),
    .vramWe   (vramWe)
  );

  hostPortData u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .vramRdata (vramRdata),
    .regIndex  (regIndex),
    .cpuRdata  (cpuRdata),
    .vramAddr  (vramAddr),
    .vramWdata (vramWdata)
  );

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    vramReq && !vramGnt |=> $stable(vramAddr) && $stable(vramWdata) && $stable(vramWe)); // R10
endmodule

// File: tb/test_vramHostPort.sv
module test_vramHostPort;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
  } txnT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSel = 1'b0, cpuWr = 1'b0;
  logic [1:0]  cpuAddr = 2'd0;
  logic [7:0]  cpuWdata = 8'd0;
  logic [7:0]  cpuRdata;
  logic        cpuWait, busy, vramReq, vramWe;
  logic [15:0] vramAddr, vramWdata;
  logic        vramGnt = 1'b0;
  logic [15:0] vramRdata = 16'd0;

  int checks = 0, fails = 0, gntDelay = 0, lastStalls = 0;
  bit finished = 0;
  txnT expQ[$];

  logic [15:0] mWr = 0, mRd = 0, mStride = 1, mBuf = 0;
  logic [7:0]  mLatch = 0;
  logic [4:0]  mIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vramHostPort i_vramHostPort (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuWait(cpuWait), .busy(busy),
    .vramReq(vramReq), .vramWe(vramWe), .vramAddr(vramAddr), .vramWdata(vramWdata),
    .vramGnt(vramGnt), .vramRdata(vramRdata)
  );

  function automatic logic [15:0] memWord(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC3};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (vramGnt) begin
        vramGnt = 1'b0;
        cnt = 0;
      end else if (vramReq && rstN) begin
        if (cnt >= gntDelay) begin
          txnT e;
          vramRdata = memWord(vramAddr);
          vramGnt = 1'b1;
          if (expQ.size() == 0) begin
            check(1'b0, "R10 unexpected request", {15'd0, vramWe, vramAddr}, 32'd0);
          end else begin
            e = expQ.pop_front();
            check(vramWe == e.we && vramAddr == e.addr, e.we ? "R3 write addr" : "R5 read addr",
                  {15'd0, vramWe, vramAddr}, {15'd0, e.we, e.addr});
            if (e.we) check(vramWdata == e.data, "R3 write word", {16'd0, vramWdata}, {16'd0, e.data});
          end
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic access(input logic wr, input logic [1:0] a, input logic [7:0] d, output logic [7:0] r);
    bit w;
    @(negedge clk);
    cpuSel = 1'b1; cpuWr = wr; cpuAddr = a; cpuWdata = d;
    lastStalls = 0;
    forever begin
      #1;
      w = cpuWait;
      r = cpuRdata;
      @(posedge clk);
      if (!w) break;
      lastStalls++;
      @(negedge clk);
    end
    @(negedge clk);
    cpuSel = 1'b0;
  endtask

  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] r;
    if (a == 2'd0) mIdx = d[4:0];
    else if (a == 2'd2) begin
      case (mIdx)
        5'd0: mWr[7:0] = d;
        5'd1: mRd[7:0] = d;
        5'd2: mLatch = d;
        default: ;
      endcase
    end else if (a == 2'd3) begin
      case (mIdx)
        5'd0: mWr[15:8] = d;
        5'd1: begin
          mRd[15:8] = d;
          expQ.push_back('{we: 1'b0, addr: mRd, data: 16'd0});
          mBuf = memWord(mRd);
          mRd = mRd + mStride;
        end
        5'd2: begin
          expQ.push_back('{we: 1'b1, addr: mWr, data: {d, mLatch}});
          mWr = mWr + mStride;
        end
        5'd5: mStride = 16'd1 << ((d[4:3] == 2'b00) ? 0 : (d[4:3] + 4));
        default: ;
      endcase
    end
    access(1'b1, a, d, r);
  endtask

  task automatic cpuRead(input logic [1:0] a, input string tag);
    logic [7:0] r, exp;
    exp = (a == 2'd2) ? mBuf[7:0] : (a == 2'd3) ? mBuf[15:8] : 8'd0;
    if (a == 2'd3 && mIdx == 5'd2) begin
      expQ.push_back('{we: 1'b0, addr: mRd, data: 16'd0});
      mBuf = memWord(mRd);
      mRd = mRd + mStride;
    end
    access(1'b0, a, 8'd0, r);
    check(r == exp, tag, {24'd0, r}, {24'd0, exp});
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(busy == 1'b0 && vramReq == 1'b0 && cpuWait == 1'b0, "R11 idle after reset",
          {29'd0, busy, vramReq, cpuWait}, 32'd0);
    cpuRead(2'd2, "R11 buffer low zero");
    cpuRead(2'd3, "R7 index 0 high read returns buffer");
    #1 check(vramReq == 1'b0, "R7 no request on non-data read", {31'd0, vramReq}, 32'd0);

    // R1 index uses bits 4..0; R4 pointer bytes
    cpuWrite(2'd0, 8'hE0);
    cpuWrite(2'd2, 8'h34);
    cpuWrite(2'd3, 8'h12);
    cpuWrite(2'd0, 8'hA2);            // R1 selects register 2
    cpuWrite(2'd2, 8'hCD);
    cpuWrite(2'd2, 8'hEF);            // R2 latch overwrite
    #1 check(vramReq == 1'b0, "R2 low write no request", {31'd0, vramReq}, 32'd0);
    cpuWrite(2'd3, 8'h01);            // R3 commit {01,EF} at 1234
    #1 check(busy == 1'b1, "R10 busy after issue", {31'd0, busy}, 32'd1);
    cpuWrite(2'd3, 8'h02);            // R2 latch reused
    drain();

    // R9 strides
    gntDelay = 2;
    for (int s = 1; s < 4; s++) begin
      cpuWrite(2'd0, 8'h05);
      cpuWrite(2'd3, 8'(s << 3));
      cpuWrite(2'd0, 8'h02);
      cpuWrite(2'd3, 8'(8'h10 + s));
      cpuWrite(2'd3, 8'(8'h20 + s));
    end
    drain();

    // R4 low byte only of write pointer
    cpuWrite(2'd0, 8'h00);
    cpuWrite(2'd2, 8'h77);
    cpuWrite(2'd0, 8'h02);
    cpuWrite(2'd3, 8'h55);
    drain();

    // R8 wrap of write pointer with stride 1
    cpuWrite(2'd0, 8'h05);
    cpuWrite(2'd3, 8'h00);
    cpuWrite(2'd0, 8'h00);
    cpuWrite(2'd2, 8'hFF);
    cpuWrite(2'd3, 8'hFF);
    cpuWrite(2'd0, 8'h02);
    cpuWrite(2'd3, 8'hA1);
    cpuWrite(2'd3, 8'hA2);
    drain();

    // R5 / R6 reads
    gntDelay = 1;
    cpuWrite(2'd0, 8'h01);
    cpuWrite(2'd2, 8'h10);
    #1 check(vramReq == 1'b0, "R5 low pointer write no request", {31'd0, vramReq}, 32'd0);
    cpuWrite(2'd3, 8'h20);
    cpuWrite(2'd0, 8'h02);
    cpuRead(2'd2, "R5 buffer low after pointer load");
    cpuRead(2'd3, "R6 high read returns buffer");
    cpuRead(2'd2, "R6 low read after reload");
    cpuRead(2'd3, "R6 repeated high read");
    cpuRead(2'd3, "R6 repeated high read");
    drain();

    // R8 wrap of read pointer, R9 stride 128 on reads
    cpuWrite(2'd0, 8'h01);
    cpuWrite(2'd2, 8'hFF);
    cpuWrite(2'd3, 8'hFF);
    cpuWrite(2'd0, 8'h02);
    cpuRead(2'd3, "R8 read across wrap");
    cpuRead(2'd3, "R8 read after wrap");
    cpuWrite(2'd0, 8'h05);
    cpuWrite(2'd3, 8'h18);
    cpuWrite(2'd0, 8'h02);
    cpuRead(2'd3, "R9 read stride");
    cpuRead(2'd3, "R9 read stride");
    cpuWrite(2'd0, 8'h05);
    cpuRead(2'd2, "R7 control selected low read");
    cpuRead(2'd3, "R7 control selected high read");
    #1 check(vramReq == 1'b0, "R7 no reload", {31'd0, vramReq}, 32'd0);
    drain();

    // R10 stall, not dropped
    gntDelay = 5;
    cpuWrite(2'd0, 8'h02);
    cpuWrite(2'd3, 8'h66);
    cpuWrite(2'd2, 8'h99);
    check(lastStalls > 0, "R10 access stalled while busy", lastStalls, 1);
    cpuWrite(2'd3, 8'h88);
    cpuRead(2'd3, "R10 read after stalled write");
    drain();
    check(expQ.size() == 0, "R10 all requests seen", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule